// File: doc/BRIEF.md
# Indirect Command/Status Register Bank for a Bus-Master Ethernet Controller

This block is the host-facing register file of a bus-master Ethernet controller. The host never addresses a register directly. It first writes a register number into a 16-bit selector port. It then reads or writes the chosen register through a 16-bit data port. The same bus carries both ports, and a single select input tells them apart.

Register 0 is the command/status word. It combines several kinds of bit in one word:
- one-cycle command strobes that go to the DMA engines,
- a run/stop state,
- an interrupt-enable level,
- sticky event flags that are raised by single-cycle pulses from the transmit, receive and memory logic, and cleared by writing ones,
- a derived error summary bit.

The bank also holds the descriptor-block address, a 64-bit multicast filter, a mode word with a promiscuous-receive bit, a fixed 32-bit identity, and a saturating counter of dropped frames. The interrupt output is derived from the command/status word.

Top module: `csr_bank`

## Requirements
- R1: A write with `port_sel`=0 loads the low ADDR_W bits of `wdata` into the selector. A read with `port_sel`=0 returns the selector, zero-extended to 16 bits.
- R2: After reset, the selector is 0, register 0 reads 0x0004, `irq` and `running` are low, and register 112 reads 0.
- R3: In a register-0 write, bit 2 (stop) sets the stop bit and drops `running`. Bit 1 (start) without bit 2 raises `running` and clears the stop bit. When both are written, stop wins. `running` reads back at bit 1 of register 0.
- R4: In a register-0 write without bit 2, bit 0 gives a one-cycle `init_strobe` and bit 3 gives a one-cycle `tdmd_strobe`. Both bits always read as 0.
- R5: Bit 6 (interrupt enable) takes the written value on every register-0 write.
- R6: Events set sticky flags in register 0: init-done sets bit 8, tx-done sets bit 9, rx-done sets bit 10, memory error sets bit 11, missed frame sets bit 12, and babble sets bit 14. Writing a one to a flag bit clears it. Writing a zero has no effect. An event in the same cycle as its clear leaves the flag set.
- R7: Bit 15 of register 0 reads as the OR of bits 14, 12 and 11.
- R8: `irq` is high exactly when bit 6 is set and any of bits 15, 10, 9 or 8 is set.
- R9: Registers 1 and 2 hold the low and high halves of `init_addr`. Both read back what was written.
- R10: Register 15 is a read/write mode word. `promisc` follows its bit 15.
- R11: Registers 8 to 11 are four independent read/write filter words.
- R12: Registers 88 and 89 read the low and high halves of CHIP_ID, whose low 12 bits are 0x003. Writes to them are ignored.
- R13: Register 112 counts missed-frame pulses and holds at its all-ones value. Writes to it are ignored.
- R14: A write to any other register number changes nothing. A read of any other register number returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 1 | 0 selects the selector port, 1 selects the data port |
| wr_en | input | 1 | Write strobe for the selected port |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected port |
| ev_init_done | input | 1 | Pulse: descriptor-block load finished |
| ev_tx_done | input | 1 | Pulse: frame transmitted |
| ev_rx_done | input | 1 | Pulse: frame received |
| ev_mem_err | input | 1 | Pulse: bus-master memory error |
| ev_missed | input | 1 | Pulse: frame dropped for lack of a buffer |
| ev_babble | input | 1 | Pulse: transmitter over-length |
| irq | output | 1 | Interrupt request |
| init_strobe | output | 1 | One-cycle init command to DMA |
| tdmd_strobe | output | 1 | One-cycle transmit-poll command to DMA |
| running | output | 1 | Controller run state |
| init_addr | output | 32 | Descriptor-block address |
| promisc | output | 1 | Promiscuous receive enable |

## Verification
The bench builds the bank with MISS_CNT_W=4 and keeps the other parameters at their defaults. The narrow counter then saturates after 15 pulses, so the hold-at-maximum behaviour is reached within a short run. The bench sweeps all 128 selector values and all 64 combinations of the six event inputs. For each event combination it computes the summary bit and the interrupt level arithmetically, with the interrupt enable both off and on.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;
  localparam int unsigned WORD_W = 16;

  // Register 0 bit positions
  localparam int unsigned B_INIT = 0;
  localparam int unsigned B_STRT = 1;
  localparam int unsigned B_STOP = 2;
  localparam int unsigned B_TDMD = 3;
  localparam int unsigned B_INEA = 6;
  localparam int unsigned B_IDON = 8;
  localparam int unsigned B_TINT = 9;
  localparam int unsigned B_RINT = 10;
  localparam int unsigned B_MERR = 11;
  localparam int unsigned B_MISS = 12;
  localparam int unsigned B_BABL = 14;
  localparam int unsigned B_ERR  = 15;

  localparam logic [WORD_W-1:0] FLAG_MASK = 16'h5F00;

  // Register numbers
  localparam int unsigned N_CMD     = 0;
  localparam int unsigned N_IADR_LO = 1;
  localparam int unsigned N_IADR_HI = 2;
  localparam int unsigned N_FILT0   = 8;
  localparam int unsigned N_MODE    = 15;
  localparam int unsigned N_ID_LO   = 88;
  localparam int unsigned N_ID_HI   = 89;
  localparam int unsigned N_MISS    = 112;
endpackage

// File: rtl/csr_cmd_status.sv
module csr_cmd_status
  import csr_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] evt_word,
  output logic [WORD_W-1:0] csr0_word,
  output logic              irq,
  output logic              init_strobe,
  output logic              tdmd_strobe,
  output logic              running
);
  logic              run_q, run_d;
  logic              stop_q, stop_d;
  logic              inea_q, inea_d;
  logic              init_q, init_d;
  logic              tdmd_q, tdmd_d;
  logic [WORD_W-1:0] flags_q, flags_d;
  logic [WORD_W-1:0] clr_mask;
  logic              err_sum;

  always_comb begin
    run_d    = run_q;
    stop_d   = stop_q;
    inea_d   = inea_q;
    init_d   = 1'b0;
    tdmd_d   = 1'b0;
    clr_mask = '0;
    if (wr_cmd) begin
      inea_d   = wdata[B_INEA];
      clr_mask = wdata & FLAG_MASK;
      if (wdata[B_STOP]) begin
        stop_d = 1'b1;
        run_d  = 1'b0;
      end else begin
        init_d = wdata[B_INIT];
        tdmd_d = wdata[B_TDMD];
        if (wdata[B_STRT]) begin
          run_d  = 1'b1;
          stop_d = 1'b0;
        end
      end
    end
    // new events take precedence over a simultaneous acknowledge
    flags_d = (flags_q & ~clr_mask) | (evt_word & FLAG_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      stop_q  <= 1'b1;
      inea_q  <= 1'b0;
      init_q  <= 1'b0;
      tdmd_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      run_q   <= run_d;
      stop_q  <= stop_d;
      inea_q  <= inea_d;
      init_q  <= init_d;
      tdmd_q  <= tdmd_d;
      flags_q <= flags_d;
    end
  end

  assign err_sum = flags_q[B_BABL] | flags_q[B_MISS] | flags_q[B_MERR];

  always_comb begin
    csr0_word         = flags_q & FLAG_MASK;
    csr0_word[B_ERR]  = err_sum;
    csr0_word[B_INEA] = inea_q;
    csr0_word[B_STOP] = stop_q;
    csr0_word[B_STRT] = run_q;
  end

  assign irq = inea_q & (err_sum | flags_q[B_RINT] | flags_q[B_TINT] | flags_q[B_IDON]);
  assign init_strobe = init_q;
  assign tdmd_strobe = tdmd_q;
  assign running     = run_q;
endmodule

// File: rtl/csr_miss_counter.sv
module csr_miss_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = inc && (cnt_q != CNT_MAX);
  assign cnt_d  = cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/csr_word_store.sv
module csr_word_store #(
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned W       = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [((N_WORDS > 1) ? $clog2(N_WORDS) : 1)-1:0] idx,
  input  logic [W-1:0]                          wdata,
  output logic [N_WORDS*W-1:0]                  words
);
  localparam int unsigned IDX_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic         en;
    logic [W-1:0] q;
    assign en = wr_en && (idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wdata;
    end
    assign words[g*W +: W] = q;
  end
endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W       = 7,
  parameter int unsigned FILTER_WORDS = 4,
  parameter int unsigned MISS_CNT_W   = 16,
  parameter logic [31:0] CHIP_ID      = 32'h0262_1003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_sel,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        ev_init_done,
  input  logic        ev_tx_done,
  input  logic        ev_rx_done,
  input  logic        ev_mem_err,
  input  logic        ev_missed,
  input  logic        ev_babble,
  output logic        irq,
  output logic        init_strobe,
  output logic        tdmd_strobe,
  output logic        running,
  output logic [31:0] init_addr,
  output logic        promisc
);
  localparam int unsigned FIDX_W = (FILTER_WORDS > 1) ? $clog2(FILTER_WORDS) : 1;

  logic [ADDR_W-1:0]              addr_q, addr_d;
  logic                           addr_en;
  logic                           data_wr;
  logic [WORD_W-1:0]              evt_word;
  logic [WORD_W-1:0]              csr0_word;
  logic [2*WORD_W-1:0]            iadr_words;
  logic [FILTER_WORDS*WORD_W-1:0] filt_words;
  logic [WORD_W-1:0]              mode_word;
  logic [MISS_CNT_W-1:0]          miss_cnt;
  logic [WORD_W-1:0]              csr_rd;
  logic                           hit_cmd, hit_iadr, hit_filt, hit_mode;
  logic [0:0]                     iadr_idx;
  logic [FIDX_W-1:0]              filt_idx;
  logic [0:0]                     mode_idx;

  // selector register
  assign addr_en = wr_en && !port_sel;
  assign addr_d  = wdata[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  // decode
  assign data_wr  = wr_en && port_sel;
  assign hit_cmd  = (addr_q == ADDR_W'(N_CMD));
  assign hit_iadr = (addr_q == ADDR_W'(N_IADR_LO)) || (addr_q == ADDR_W'(N_IADR_HI));
  assign hit_filt = (addr_q >= ADDR_W'(N_FILT0)) &&
                    (addr_q <  ADDR_W'(N_FILT0 + FILTER_WORDS));
  assign hit_mode = (addr_q == ADDR_W'(N_MODE));
  assign iadr_idx = (addr_q == ADDR_W'(N_IADR_HI));
  assign filt_idx = FIDX_W'(addr_q - ADDR_W'(N_FILT0));
  assign mode_idx = 1'b0;

  always_comb begin
    evt_word         = '0;
    evt_word[B_IDON] = ev_init_done;
    evt_word[B_TINT] = ev_tx_done;
    evt_word[B_RINT] = ev_rx_done;
    evt_word[B_MERR] = ev_mem_err;
    evt_word[B_MISS] = ev_missed;
    evt_word[B_BABL] = ev_babble;
  end

  csr_cmd_status u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_cmd      (data_wr && hit_cmd),
    .wdata       (wdata),
    .evt_word    (evt_word),
    .csr0_word   (csr0_word),
    .irq         (irq),
    .init_strobe (init_strobe),
    .tdmd_strobe (tdmd_strobe),
    .running     (running)
  );

  csr_word_store #(.N_WORDS(2), .W(WORD_W)) u_iadr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (data_wr && hit_iadr),
    .idx   (iadr_idx),
    .wdata (wdata),
    .words (iadr_words)
  );

  csr_word_store #(.N_WORDS(FILTER_WORDS), .W(WORD_W)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (data_wr && hit_filt),
    .idx   (filt_idx),
    .wdata (wdata),
    .words (filt_words)
  );

  csr_word_store #(.N_WORDS(1), .W(WORD_W)) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (data_wr && hit_mode),
    .idx   (mode_idx),
    .wdata (wdata),
    .words (mode_word)
  );

  csr_miss_counter #(.CNT_W(MISS_CNT_W)) u_miss (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ev_missed),
    .count (miss_cnt)
  );

  // read mux
  always_comb begin
    csr_rd = '0;
    if (hit_cmd)                              csr_rd = csr0_word;
    else if (hit_iadr)                        csr_rd = iadr_words[iadr_idx*WORD_W +: WORD_W];
    else if (hit_filt)                        csr_rd = filt_words[filt_idx*WORD_W +: WORD_W];
    else if (hit_mode)                        csr_rd = mode_word;
    else if (addr_q == ADDR_W'(N_ID_LO))      csr_rd = CHIP_ID[15:0];
    else if (addr_q == ADDR_W'(N_ID_HI))      csr_rd = CHIP_ID[31:16];
    else if (addr_q == ADDR_W'(N_MISS))       csr_rd = WORD_W'(miss_cnt);
  end

  assign rdata     = port_sel ? csr_rd : WORD_W'(addr_q);
  assign init_addr = iadr_words;
  assign promisc   = mode_word[15];
endmodule

// File: rtl/csr_bank_chk.sv
module csr_bank_chk
  import csr_bank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned MISS_CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  port_sel,
  input logic                  wr_en,
  input logic [15:0]           wdata,
  input logic                  ev_rx_done,
  input logic                  irq,
  input logic                  init_strobe,
  input logic                  running,
  input logic [ADDR_W-1:0]     addr_q,
  input logic [15:0]           csr0_word,
  input logic [MISS_CNT_W-1:0] miss_cnt
);
  localparam logic [MISS_CNT_W-1:0] CNT_MAX = {MISS_CNT_W{1'b1}};

  assert_sel_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !port_sel) |=> (addr_q == $past(wdata[ADDR_W-1:0])));

  assert_run_stop_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(running && csr0_word[B_STOP]));

  assert_init_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    init_strobe |-> $past(wr_en && port_sel && (addr_q == '0) && wdata[B_INIT]));

  assert_rint_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_done |=> csr0_word[B_RINT]);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> csr0_word[B_INEA]);

  assert_cnt_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt == CNT_MAX) |=> (miss_cnt == CNT_MAX));
endmodule

bind csr_bank csr_bank_chk #(.ADDR_W(ADDR_W), .MISS_CNT_W(MISS_CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .port_sel    (port_sel),
  .wr_en       (wr_en),
  .wdata       (wdata),
  .ev_rx_done  (ev_rx_done),
  .irq         (irq),
  .init_strobe (init_strobe),
  .running     (running),
  .addr_q      (addr_q),
  .csr0_word   (csr0_word),
  .miss_cnt    (miss_cnt)
);

// File: tb/test_csr_bank.sv
module test_csr_bank;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        port_sel, wr_en;
  logic [15:0] wdata, rdata;
  logic        ev_init_done, ev_tx_done, ev_rx_done, ev_mem_err, ev_missed, ev_babble;
  logic        irq, init_strobe, tdmd_strobe, running, promisc;
  logic [31:0] init_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_bank #(.MISS_CNT_W(CNT_W)) i_csr_bank (
    .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata),
    .ev_init_done(ev_init_done), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
    .ev_mem_err(ev_mem_err), .ev_missed(ev_missed), .ev_babble(ev_babble),
    .irq(irq), .init_strobe(init_strobe), .tdmd_strobe(tdmd_strobe),
    .running(running), .init_addr(init_addr), .promisc(promisc)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] v);
    @(negedge clk);
    port_sel = sel; wr_en = 1'b1; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input int num, output logic [15:0] v);
    wr(1'b0, 16'(num));
    port_sel = 1'b1;
    #1 v = rdata;
  endtask

  task automatic wr_reg(input int num, input logic [15:0] v);
    wr(1'b0, 16'(num));
    wr(1'b1, v);
  endtask

  task automatic pulse(input logic [5:0] m);
    @(negedge clk);
    {ev_babble, ev_missed, ev_mem_err, ev_rx_done, ev_tx_done, ev_init_done} = m;
    @(negedge clk);
    {ev_babble, ev_missed, ev_mem_err, ev_rx_done, ev_tx_done, ev_init_done} = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] flag_bits(input logic [5:0] m);
    logic [15:0] f;
    f = 16'(m[0]) << 8 | 16'(m[1]) << 9 | 16'(m[2]) << 10 |
        16'(m[3]) << 11 | 16'(m[4]) << 12 | 16'(m[5]) << 14;
    if (m[3] | m[4] | m[5]) f |= 16'h8000;
    return f;
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    port_sel = 0; wr_en = 0; wdata = '0;
    {ev_babble, ev_missed, ev_mem_err, ev_rx_done, ev_tx_done, ev_init_done} = '0;
    do_reset();

    // R2 reset state
    port_sel = 1'b0; #1 check(rdata, 16'h0, "R2 selector");
    port_sel = 1'b1; #1 check(rdata, 16'h0004, "R2 reg0");
    check(irq, 0, "R2 irq"); check(running, 0, "R2 running");
    rd_reg(112, v); check(v, 0, "R2 miss count");

    // R1 selector sweep
    for (int a = 0; a < 128; a++) begin
      wr(1'b0, 16'(a) | 16'hFF80);
      port_sel = 1'b0; #1 check(rdata, 16'(a), "R1 selector readback");
    end

    // R3 run/stop
    wr_reg(0, 16'h0002); port_sel = 1; #1 check(rdata, 16'h0002, "R3 start reg0");
    check(running, 1, "R3 start running");
    wr(1'b1, 16'h0004); #1 check(rdata, 16'h0004, "R3 stop reg0");
    check(running, 0, "R3 stop running");
    wr(1'b1, 16'h0006); #1 check(rdata, 16'h0004, "R3 both stop wins");
    check(running, 0, "R3 both running");

    // R4 strobes
    wr(1'b1, 16'h0001);
    check(init_strobe, 1, "R4 init strobe"); check(tdmd_strobe, 0, "R4 no tdmd");
    @(negedge clk); check(init_strobe, 0, "R4 init one cycle");
    #1 check(rdata, 16'h0004, "R4 init reads zero");
    wr(1'b1, 16'h0008);
    check(tdmd_strobe, 1, "R4 tdmd strobe"); check(init_strobe, 0, "R4 no init");
    @(negedge clk); check(tdmd_strobe, 0, "R4 tdmd one cycle");
    wr(1'b1, 16'h000D);
    check({init_strobe, tdmd_strobe}, 0, "R4 stop suppresses strobes");

    // R5 interrupt enable
    wr(1'b1, 16'h0040); #1 check(rdata, 16'h0044, "R5 enable set");
    wr(1'b1, 16'h0000); #1 check(rdata, 16'h0004, "R5 enable cleared");

    // R6 R7 R8 event sweep
    for (int m = 0; m < 64; m++) begin
      logic [15:0] f;
      f = flag_bits(6'(m));
      wr_reg(0, 16'h5F00);
      pulse(6'(m));
      port_sel = 1; #1 check(rdata, 16'h0004 | f, "R6 R7 flags set");
      check(irq, 0, "R8 irq masked");
      wr(1'b1, 16'h0040); #1 check(rdata, 16'h0044 | f, "R6 sticky after zero write");
      check(irq, (f & 16'h8700) != 0, "R8 irq enabled");
      wr(1'b1, f & 16'h5F00); #1 check(rdata, 16'h0004, "R6 acknowledge clears");
      check(irq, 0, "R8 irq after clear");
    end
    // R6 set beats clear in same cycle
    wr_reg(0, 16'h0000);
    pulse(6'b000100);
    @(negedge clk);
    port_sel = 1; wr_en = 1; wdata = 16'h0400; ev_rx_done = 1;
    @(negedge clk);
    wr_en = 0; ev_rx_done = 0;
    #1 check(rdata, 16'h0404, "R6 event wins over clear");
    wr(1'b1, 16'h0400);

    // R9 init address
    wr_reg(1, 16'h1234); wr_reg(2, 16'hABCD);
    rd_reg(1, v); check(v, 16'h1234, "R9 low");
    rd_reg(2, v); check(v, 16'hABCD, "R9 high");
    check(init_addr, 32'hABCD1234, "R9 output");

    // R10 mode
    wr_reg(15, 16'h8000); rd_reg(15, v); check(v, 16'h8000, "R10 mode read");
    check(promisc, 1, "R10 promisc on");
    wr_reg(15, 16'h0123); rd_reg(15, v); check(v, 16'h0123, "R10 mode read2");
    check(promisc, 0, "R10 promisc off");

    // R11 filter
    for (int i = 0; i < 4; i++) wr_reg(8 + i, 16'(16'h1111 * (i + 1)));
    for (int i = 0; i < 4; i++) begin
      rd_reg(8 + i, v); check(v, 16'(16'h1111 * (i + 1)), "R11 filter word");
    end

    // R12 identity
    wr_reg(88, 16'hFFFF); wr_reg(89, 16'h0000);
    rd_reg(88, v); check(v, 16'h1003, "R12 id low");
    check(v[11:0], 12'h003, "R12 id low bits");
    rd_reg(89, v); check(v, 16'h0262, "R12 id high");

    // R14 unimplemented numbers
    foreach (v[k]) begin end
    for (int k = 0; k < 7; k++) begin
      int nums[7] = '{3, 4, 7, 12, 16, 50, 127};
      wr_reg(nums[k], 16'hBEEF);
      rd_reg(nums[k], v); check(v, 0, "R14 reads zero");
    end
    rd_reg(1, v); check(v, 16'h1234, "R14 neighbour intact");
    rd_reg(15, v); check(v, 16'h0123, "R14 mode intact");
    rd_reg(0, v); check(v, 16'h0004, "R14 reg0 intact");

    // R13 missed-frame counter
    do_reset();
    for (int k = 1; k <= 20; k++) begin
      pulse(6'b010000);
      rd_reg(112, v); check(v, 16'((k > 15) ? 15 : k), "R13 count");
    end
    wr_reg(112, 16'h0000); rd_reg(112, v); check(v, 16'h000F, "R13 write ignored");
    rd_reg(0, v); check(v, 16'h9004, "R13 miss flag and summary");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule